// File: doc/BRIEF.md
# Two-Wire Serial Register Access Slave

This block lets a host on a two-wire serial bus (I2C-compatible) read and write a small bank of byte registers. The bank lives outside the block. The slave oversamples the bus clock and data lines with a fast system clock and recognises the bus framing conditions. It pulls the data line low through an open-drain control output whenever it acknowledges a byte or sends a zero.

A write transfer carries three kinds of byte:

- the device address with the direction bit,
- a register pointer,
- one or more data bytes.

Each data byte is presented on a one-cycle write port, and the pointer then advances. A read transfer returns the byte at the current pointer, most significant bit first. It keeps returning bytes, each from the next pointer value, for as long as the host acknowledges them.

The device address is one of two values, chosen by a strap input, so two of these slaves can share one bus. Any data-line change while the clock is high ends the byte in progress. A falling change restarts the address phase and a rising change frees the bus, so a partly received data byte is never written.

Top module: `i2c_regslave`

## Requirements
- R1: After reset the data line is released (`sda_pd_o` = 0) and no write strobe is issued.
- R2: SDA falling while SCL is high is a START and SDA rising while SCL is high is a STOP. A repeated START with no STOP in between restarts the address phase exactly as a first START does.
- R3: The slave answers the 7-bit address 0x54 when `sel_i` = 0 and 0x55 when `sel_i` = 1. The address is sent MSB first and followed by a direction bit (0 = write, 1 = read). The slave acknowledges by pulling SDA low during the ninth clock.
- R4: After an address that does not match, the slave acknowledges nothing, issues no write and drives nothing until the next START.
- R5: In a write, the byte after the address loads the register pointer and the next byte is written to that register. The write is a single-cycle `wr_en_o` pulse carrying `wr_addr_o` and `wr_data_o`, issued at the start of that byte's acknowledge. Every received byte is acknowledged.
- R6: The pointer increases by one after each data byte, so consecutive data bytes in one write go to consecutive registers.
- R7: In a read, the slave sends `rd_data_i` for the current pointer, MSB first, and the pointer then increases by one. When the host acknowledges, the next byte follows.
- R8: When the host does not acknowledge a read byte, the slave releases SDA and drives nothing more until the next START.
- R9: A START or STOP in the middle of a byte abandons that byte, so a partial data byte causes no write.
- R10: `sda_pd_o` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the bus bit rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sel_i | input | 1 | Address strap: 0 selects 0x54, 1 selects 0x55 |
| sda_pd_o | output | 1 | 1 pulls the data line low (open-drain) |
| wr_en_o | output | 1 | One-cycle register write strobe |
| wr_addr_o | output | AW | Register index for the write |
| wr_data_o | output | 8 | Byte to write |
| rd_addr_o | output | AW | Register index currently pointed to |
| rd_data_i | input | 8 | Contents of the register at `rd_addr_o` |

## Verification
The assertions assume the bus lines stay stable for several system clocks around each SCL edge. The host must change SDA only while SCL is low, except when it deliberately makes a START or STOP, and it must release SDA whenever the slave owns the line. The bench master holds every bus level for 20 system clocks. After each falling SCL edge it waits four clocks before it moves SDA, so the two-flop synchronizers always see a clean order of edges. It makes mid-byte aborts only through its START and STOP tasks.

// File: rtl/i2c_regslave.sv
`timescale 1ns/100ps
module i2c_regslave #(
  parameter logic [6:0] BASE_ADDR = 7'h54,
  parameter int         AW        = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  input  logic          sel_i,
  output logic          sda_pd_o,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [7:0]    wr_data_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic [7:0]    rd_data_i
);
  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_REG, S_DATA, S_READ, S_SKIP} st_t;

  logic [2:0]    scl_r, sda_r;
  st_t           st;
  logic [3:0]    cnt;
  logic          ackph, mnack, pd;
  logic [7:0]    sh;
  logic [AW-1:0] ptr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_r <= 3'b111;
      sda_r <= 3'b111;
    end else begin
      scl_r <= {scl_r[1:0], scl_i};
      sda_r <= {sda_r[1:0], sda_i};
    end

  wire scl_s = scl_r[1];
  wire scl_q = scl_r[2];
  wire sda_s = sda_r[1];
  wire sda_q = sda_r[2];
  wire start_c = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_c  = scl_s & scl_q & ~sda_q & sda_s;
  wire rise    = scl_s & ~scl_q;
  wire fall    = ~scl_s & scl_q;
  wire [6:0] my_addr = {BASE_ADDR[6:1], BASE_ADDR[0] | sel_i};
  wire rx_st = (st == S_ADDR) || (st == S_REG) || (st == S_DATA);

  assign sda_pd_o  = pd;
  assign rd_addr_o = ptr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      ackph     <= 1'b0;
      mnack     <= 1'b0;
      pd        <= 1'b0;
      sh        <= '0;
      ptr       <= '0;
      wr_en_o   <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
    end else begin
      wr_en_o <= 1'b0;
      if (start_c) begin
        st    <= S_ADDR;
        cnt   <= '0;
        ackph <= 1'b0;
        pd    <= 1'b0;
      end else if (stop_c) begin
        st    <= S_IDLE;
        cnt   <= '0;
        ackph <= 1'b0;
        pd    <= 1'b0;
      end else if (rx_st) begin
        if (rise && !ackph) begin
          sh  <= {sh[6:0], sda_s};
          cnt <= cnt + 4'd1;
        end else if (fall && !ackph && cnt == 4'd8) begin
          if (st == S_ADDR && sh[7:1] != my_addr) begin
            st  <= S_SKIP;
            cnt <= '0;
          end else begin
            ackph <= 1'b1;
            pd    <= 1'b1;
          end
          if (st == S_REG) ptr <= sh[AW-1:0];
          if (st == S_DATA) begin
            wr_en_o   <= 1'b1;
            wr_addr_o <= ptr;
            wr_data_o <= sh;
            ptr       <= ptr + 1'b1;
          end
        end else if (fall && ackph) begin
          ackph <= 1'b0;
          cnt   <= '0;
          pd    <= 1'b0;
          if (st == S_ADDR && sh[0]) begin
            st <= S_READ;
            sh <= rd_data_i;
            pd <= ~rd_data_i[7];
          end else if (st == S_ADDR) st <= S_REG;
          else st <= S_DATA;
        end
      end else if (st == S_READ) begin
        if (rise && ackph) mnack <= sda_s;
        else if (rise) cnt <= cnt + 4'd1;
        else if (fall && !ackph) begin
          if (cnt == 4'd8) begin
            pd    <= 1'b0;
            ackph <= 1'b1;
            ptr   <= ptr + 1'b1;
          end else if (cnt != 4'd0) begin
            pd <= ~sh[6];
            sh <= {sh[6:0], 1'b0};
          end
        end else if (fall && ackph) begin
          ackph <= 1'b0;
          cnt   <= '0;
          if (mnack) st <= S_SKIP;
          else begin
            sh <= rd_data_i;
            pd <= ~rd_data_i[7];
          end
        end
      end
    end

  a_r5_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |=> !wr_en_o);
  a_r10_pd_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_pd_o != $past(sda_pd_o)) |-> !scl_s);
  a_r4_skip_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SKIP) |-> (!sda_pd_o && !wr_en_o));
  a_r2_stop_frees: assert property (@(posedge clk) disable iff (!rst_n)
    stop_c |=> (st == S_IDLE && !sda_pd_o));
  a_r9_abort_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (start_c || stop_c) |=> !wr_en_o);
endmodule

// File: tb/test_i2c_regslave.sv
`timescale 1ns/100ps
module test_i2c_regslave;
  localparam int HP = 20;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1, sel = 1'b0;
  logic pd, wr_en;
  logic [3:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;
  wire sda_line = sda_m & ~pd;

  i2c_regslave i_i2c_regslave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sel_i(sel),
    .sda_pd_o(pd), .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .rd_addr_o(rd_addr), .rd_data_i(rd_data));

  logic [7:0] bank [16];
  logic [7:0] mdl [16];
  always @(posedge clk)
    if (!rst_n) for (int i = 0; i < 16; i++) bank[i] <= 8'h10 + 8'(i);
    else if (wr_en) bank[wr_addr] <= wr_data;
  assign rd_data = bank[rd_addr];

  int total = 0, bad = 0, pdflips = 0;
  int qa[$], qd[$];
  bit done = 0;
  logic prev_scl = 1'b1, prev_pd = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && wr_en) begin
      if (qa.size() == 0) chk(0, "R5 unexpected write", {wr_addr, wr_data}, 0);
      else begin
        int a, d;
        a = qa.pop_front();
        d = qd.pop_front();
        chk(wr_addr == 4'(a) && wr_data == 8'(d), "R5/R6 write port", {wr_addr, wr_data}, {a[3:0], d[7:0]});
      end
    end
    if (rst_n && scl && prev_scl && pd != prev_pd) pdflips++;
    prev_scl = scl;
    prev_pd  = pd;
  end

  task automatic expect_wr(input int a, input int d);
    qa.push_back(a);
    qd.push_back(d);
    mdl[a] = 8'(d);
  endtask

  task automatic hp(input int n = HP);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1; hp(); scl = 1; hp(); sda_m = 0; hp(); scl = 0; hp(4);
  endtask

  task automatic bus_stop();
    sda_m = 0; hp(); scl = 1; hp(); sda_m = 1; hp();
  endtask

  task automatic send_bit(input bit b);
    sda_m = b; hp(); scl = 1; hp(); scl = 0; hp(4);
  endtask

  task automatic wr_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1; hp(); scl = 1; hp(HP/2); ack = !sda_line; hp(HP/2); scl = 0; hp(4);
  endtask

  task automatic rd_byte(input bit nack, output logic [7:0] d);
    sda_m = 1;
    for (int i = 7; i >= 0; i--) begin
      hp(); scl = 1; hp(HP/2); d[i] = sda_line; hp(HP/2); scl = 0; hp(4);
    end
    sda_m = nack; hp(); scl = 1; hp(); scl = 0; hp(4); sda_m = 1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      chk(0, "watchdog expired", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    bit ack;
    logic [7:0] d;
    for (int i = 0; i < 16; i++) mdl[i] = 8'h10 + 8'(i);
    hp(5);
    chk(pd == 0 && wr_en == 0, "R1 reset outputs", {pd, wr_en}, 0);
    rst_n = 1;
    hp(10);
    chk(pd == 0, "R1 released after reset", pd, 0);

    // R3, R5, R6: write two bytes with sel low
    bus_start();
    wr_byte(8'hA8, ack); chk(ack, "R3 ack 0x54 sel=0", ack, 1);
    wr_byte(8'h03, ack); chk(ack, "R5 ack pointer", ack, 1);
    expect_wr(3, 8'hA5);
    wr_byte(8'hA5, ack); chk(ack, "R5 ack data", ack, 1);
    expect_wr(4, 8'h5A);
    wr_byte(8'h5A, ack); chk(ack, "R6 ack second data", ack, 1);
    bus_stop();

    // R4: wrong address ignored
    bus_start();
    wr_byte(8'hAA, ack); chk(!ack, "R4 no ack 0x55 sel=0", ack, 0);
    wr_byte(8'h02, ack); chk(!ack, "R4 no ack after mismatch", ack, 0);
    wr_byte(8'h77, ack); chk(!ack, "R4 no ack data after mismatch", ack, 0);
    bus_stop();
    chk(pd == 0, "R4 line released", pd, 0);

    // R3 with sel high
    sel = 1;
    bus_start();
    wr_byte(8'hAA, ack); chk(ack, "R3 ack 0x55 sel=1", ack, 1);
    wr_byte(8'h09, ack);
    expect_wr(9, 8'hC3);
    wr_byte(8'hC3, ack);
    bus_stop();
    bus_start();
    wr_byte(8'hA8, ack); chk(!ack, "R3 no ack 0x54 sel=1", ack, 0);
    bus_stop();

    // R2, R7, R8: set pointer, repeated START, read
    bus_start();
    wr_byte(8'hAA, ack);
    wr_byte(8'h03, ack);
    bus_start();
    wr_byte(8'hAB, ack); chk(ack, "R2 ack after repeated START", ack, 1);
    rd_byte(0, d); chk(d == mdl[3], "R7 read first byte", d, mdl[3]);
    rd_byte(1, d); chk(d == mdl[4], "R7 read next byte after ack", d, mdl[4]);
    rd_byte(1, d); chk(d == 8'hFF, "R8 released after host nack", d, 8'hFF);
    bus_stop();

    // R2: repeated START acts like START for a write
    bus_start();
    wr_byte(8'hAA, ack);
    wr_byte(8'h05, ack);
    bus_start();
    wr_byte(8'hAA, ack);
    wr_byte(8'h06, ack);
    expect_wr(6, 8'h11);
    wr_byte(8'h11, ack); chk(ack, "R2 write after repeated START", ack, 1);
    bus_stop();

    // R9: STOP mid-byte and START mid-byte leave the register unchanged
    bus_start();
    wr_byte(8'hAA, ack);
    wr_byte(8'h09, ack);
    for (int i = 0; i < 4; i++) send_bit(1'b0);
    bus_stop();
    bus_start();
    wr_byte(8'hAA, ack);
    wr_byte(8'h09, ack);
    for (int i = 0; i < 3; i++) send_bit(1'b1);
    bus_start();
    wr_byte(8'hAB, ack); chk(ack, "R9 address after mid-byte START", ack, 1);
    rd_byte(1, d); chk(d == mdl[9], "R9 aborted byte not written", d, mdl[9]);
    bus_stop();

    // R6: pointer continues across a read
    bus_start();
    wr_byte(8'hAA, ack);
    wr_byte(8'h05, ack);
    bus_start();
    wr_byte(8'hAB, ack);
    rd_byte(0, d); chk(d == mdl[5], "R6 read at pointer", d, mdl[5]);
    rd_byte(1, d); chk(d == mdl[6], "R6 pointer incremented", d, mdl[6]);
    bus_stop();

    hp();
    chk(pdflips == 0, "R10 pull-down moved while SCL high", pdflips, 0);
    chk(qa.size() == 0, "R5 missing writes", qa.size(), 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule